// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register, a value and the tag of the in-flight operation that will produce its next value. A tag of zero means no producer is pending and the stored value is current. When an instruction issues, two source lookups return, for each operand, either the ready value (tag zero) or the tag of the producer the operand must wait for. The same cycle may name a destination register and a nonzero station tag. That tag then becomes the register's pending producer, and it replaces any older producer that is still outstanding.

The table also listens to the shared result broadcast, which carries 64-bit data and a 4-bit producer tag. A register takes a broadcast only while its recorded tag equals the broadcast tag. A register that a later issue has retargeted therefore never sees the earlier producer's result. This removes write-after-write hazards without any stall. Lookups made in the same cycle as a matching broadcast already see the broadcast value.

Top module: `rrt_table`

## Requirements
- R1: After reset every register reads tag 0 and value 0 on both lookup ports.
- R2: An issue with write enable, destination d and nonzero tag t makes lookups of d return tag t from the next cycle onward, until a broadcast of t or a newer issue to d.
- R3: A lookup of a register whose tag is 0 returns tag 0 and the stored value in the same cycle, without waiting for a clock edge.
- R4: A valid broadcast whose tag equals a register's nonzero tag writes the broadcast data into that register and sets its tag to 0 at the next edge.
- R5: A valid broadcast whose tag differs from a register's tag leaves that register's tag and value unchanged.
- R6: A second issue to a register replaces the first producer's tag, and a later broadcast of the first tag leaves that register unchanged.
- R7: When an issue to a register and a broadcast matching its old tag fall in the same cycle, the register keeps the new tag and its stored value becomes the broadcast data, which the lookup value field shows.
- R8: A lookup in the same cycle as a valid broadcast that matches the looked-up register's tag returns tag 0 and the broadcast data.
- R9: A lookup in the same cycle as an issue to the same register returns the mapping from before that issue.
- R10: A broadcast with tag 0, or with the valid input low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| iss_wr_en_i | input | 1 | Issue writes a destination this cycle |
| iss_dst_i | input | 4 | Destination register index |
| iss_tag_i | input | 4 | Station tag of the issuing instruction, nonzero |
| src_a_idx_i | input | 4 | First source register index |
| src_b_idx_i | input | 4 | Second source register index |
| src_a_tag_o | output | 4 | Pending producer tag of first source, 0 when ready |
| src_a_val_o | output | 64 | Value of first source |
| src_b_tag_o | output | 4 | Pending producer tag of second source, 0 when ready |
| src_b_val_o | output | 64 | Value of second source |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | 4 | Tag of the broadcasting producer |
| cdb_data_i | input | 64 | Broadcast result data |

## Verification
Lookup results are due in the same cycle as their indices and any broadcast they bypass. Issue and broadcast effects on the table appear one cycle later, after the next rising edge. The bench drives every input on the falling edge and compares both lookup ports one nanosecond later against a model that still holds the state from before the edge. It then advances the model at the rising edge with the inputs that were just applied. Every result is therefore checked in the cycle it is due and never half a cycle early.

// File: rtl/rrt_pkg.sv
`timescale 1ns/1ps
package rrt_pkg;
  localparam int unsigned RRT_NREGS  = 16;
  localparam int unsigned RRT_DATA_W = 64;
  localparam int unsigned RRT_TAG_W  = 4;

  // where a lookup port takes its value from
  typedef enum logic {
    RD_FROM_TABLE = 1'b0,
    RD_FROM_BUS   = 1'b1
  } rrt_rd_src_e;
endpackage

// File: rtl/rrt_rst_sync.sv
`timescale 1ns/1ps
module rrt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/rrt_entry.sv
`timescale 1ns/1ps
module rrt_entry #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_hit_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] val_o
);
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              snoop_hit;
  logic              tag_en, val_en;

  // next state
  always_comb begin
    snoop_hit = bus_valid_i && (tag_q != '0) && (bus_tag_i == tag_q);
    val_d     = snoop_hit ? bus_data_i : val_q;
    tag_d     = issue_hit_i ? issue_tag_i : (snoop_hit ? '0 : tag_q);
    val_en    = snoop_hit;
    tag_en    = snoop_hit | issue_hit_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign tag_o = tag_q;
  assign val_o = val_q;

  assert_issue_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_hit_i |=> tag_o == $past(issue_tag_i));

  assert_bus_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && tag_o != '0 && bus_tag_i == tag_o && !issue_hit_i)
      |=> (tag_o == '0 && val_o == $past(bus_data_i)));

  assert_mismatch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_hit_i && !(bus_valid_i && bus_tag_i == tag_o))
      |=> ($stable(tag_o) && $stable(val_o)));

  assert_new_tag_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_hit_i && bus_valid_i && tag_o != '0 && bus_tag_i == tag_o)
      |=> (tag_o == $past(issue_tag_i) && val_o == $past(bus_data_i)));

  assert_idle_reg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_o == '0 && !issue_hit_i) |=> (tag_o == '0 && $stable(val_o)));
endmodule

// File: rtl/rrt_read_port.sv
`timescale 1ns/1ps
module rrt_read_port
  import rrt_pkg::*;
#(
  parameter int unsigned NREGS  = 16,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [NREGS-1:0][TAG_W-1:0]   tags_i,
  input  logic [NREGS-1:0][DATA_W-1:0]  vals_i,
  input  logic                          bus_valid_i,
  input  logic [TAG_W-1:0]              bus_tag_i,
  input  logic [DATA_W-1:0]             bus_data_i,
  output logic [TAG_W-1:0]              tag_o,
  output logic [DATA_W-1:0]             val_o
);
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;
  rrt_rd_src_e       src;

  always_comb begin
    sel_tag = tags_i[idx_i];
    sel_val = vals_i[idx_i];
    src     = (bus_valid_i && (sel_tag != '0) && (bus_tag_i == sel_tag))
              ? RD_FROM_BUS : RD_FROM_TABLE;
    tag_o   = (src == RD_FROM_BUS) ? '0 : sel_tag;
    val_o   = (src == RD_FROM_BUS) ? bus_data_i : sel_val;
  end

  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && tags_i[idx_i] != '0 && bus_tag_i == tags_i[idx_i])
      |-> (tag_o == '0 && val_o == bus_data_i));

  assert_ready_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tags_i[idx_i] == '0) |-> (tag_o == '0 && val_o == vals_i[idx_i]));
endmodule

// File: rtl/rrt_table.sv
`timescale 1ns/1ps
module rrt_table
  import rrt_pkg::*;
#(
  parameter int unsigned NREGS  = RRT_NREGS,
  parameter int unsigned DATA_W = RRT_DATA_W,
  parameter int unsigned TAG_W  = RRT_TAG_W,
  localparam int unsigned IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_wr_en_i,
  input  logic [IDX_W-1:0]  iss_dst_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic [IDX_W-1:0]  src_a_idx_i,
  input  logic [IDX_W-1:0]  src_b_idx_i,
  output logic [TAG_W-1:0]  src_a_tag_o,
  output logic [DATA_W-1:0] src_a_val_o,
  output logic [TAG_W-1:0]  src_b_tag_o,
  output logic [DATA_W-1:0] src_b_val_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i
);
  localparam int unsigned NPORTS = 2;

  logic                         rst_n_int;
  logic [NREGS-1:0][TAG_W-1:0]  tags;
  logic [NREGS-1:0][DATA_W-1:0] vals;
  logic [NREGS-1:0]             issue_hit;
  logic [NPORTS-1:0][IDX_W-1:0] rd_idx;
  logic [NPORTS-1:0][TAG_W-1:0] rd_tag;
  logic [NPORTS-1:0][DATA_W-1:0] rd_val;

  rrt_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    assign issue_hit[g] = iss_wr_en_i && (iss_dst_i == IDX_W'(g));

    rrt_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_n_int),
      .issue_hit_i (issue_hit[g]),
      .issue_tag_i (iss_tag_i),
      .bus_valid_i (cdb_valid_i),
      .bus_tag_i   (cdb_tag_i),
      .bus_data_i  (cdb_data_i),
      .tag_o       (tags[g]),
      .val_o       (vals[g])
    );
  end

  assign rd_idx[0] = src_a_idx_i;
  assign rd_idx[1] = src_b_idx_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rrt_read_port #(
      .NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_n_int),
      .idx_i       (rd_idx[p]),
      .tags_i      (tags),
      .vals_i      (vals),
      .bus_valid_i (cdb_valid_i),
      .bus_tag_i   (cdb_tag_i),
      .bus_data_i  (cdb_data_i),
      .tag_o       (rd_tag[p]),
      .val_o       (rd_val[p])
    );
  end

  assign src_a_tag_o = rd_tag[0];
  assign src_a_val_o = rd_val[0];
  assign src_b_tag_o = rd_tag[1];
  assign src_b_val_o = rd_val[1];

  assert_issue_tag_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    iss_wr_en_i |-> (iss_tag_i != '0));

  assert_one_dest_R2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $onehot0(issue_hit));
endmodule

// File: tb/rrt_table_bench.sv
`timescale 1ns/1ps
module rrt_table_bench;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  dst, itag, sa, sb, btag;
  logic        bv;
  logic [63:0] bdata;
  logic [3:0]  a_tag, b_tag;
  logic [63:0] a_val, b_val;

  int n_checks = 0;
  int n_errors = 0;

  logic [3:0]  mtag [NR];
  logic [63:0] mval [NR];

  always #2.5 clk = ~clk;

  rrt_table u_rrt_table (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_wr_en_i(we), .iss_dst_i(dst), .iss_tag_i(itag),
    .src_a_idx_i(sa), .src_b_idx_i(sb),
    .src_a_tag_o(a_tag), .src_a_val_o(a_val),
    .src_b_tag_o(b_tag), .src_b_val_o(b_val),
    .cdb_valid_i(bv), .cdb_tag_i(btag), .cdb_data_i(bdata)
  );

  function automatic bit bus_hits(int r);
    return bv && (mtag[r] != 4'd0) && (btag == mtag[r]);
  endfunction

  function automatic logic [3:0] exp_tag(int r);
    return bus_hits(r) ? 4'd0 : mtag[r];
  endfunction

  function automatic logic [63:0] exp_val(int r);
    return bus_hits(r) ? bdata : mval[r];
  endfunction

  task automatic check_port(string pname, int r, logic [3:0] t, logic [63:0] v, string req);
    string lbl;
    lbl = req;
    if (lbl == "") lbl = bus_hits(r) ? "R8" : ((mtag[r] != 4'd0) ? "R2" : "R3");
    n_checks++;
    if (t !== exp_tag(r) || v !== exp_val(r)) begin
      n_errors++;
      $display("FAIL %s port %s reg %0d: tag %0d val %h, expected tag %0d val %h",
               lbl, pname, r, t, v, exp_tag(r), exp_val(r));
    end
  endtask

  task automatic cycle(bit w, int d, int t, bit v, int bt, logic [63:0] bd,
                       int ra, int rb, string req);
    @(negedge clk);
    we = w; dst = 4'(d); itag = 4'(t);
    bv = v; btag = 4'(bt); bdata = bd;
    sa = 4'(ra); sb = 4'(rb);
    #1;
    check_port("a", ra, a_tag, a_val, req);
    check_port("b", rb, b_tag, b_val, req);
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      if (bus_hits(r)) begin
        mval[r] = bdata;
        mtag[r] = 4'd0;
      end
      if (we && dst == 4'(r)) mtag[r] = itag;
    end
  endtask

  task automatic idle(int ra, int rb, string req);
    cycle(0, 0, 1, 0, 0, 64'd0, ra, rb, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    for (int r = 0; r < NR; r++) begin mtag[r] = 4'd0; mval[r] = 64'd0; end
    rst_n = 1'b0; we = 0; dst = 0; itag = 1; bv = 0; btag = 0; bdata = 0; sa = 0; sb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state on both ports
    for (int r = 0; r < NR; r += 2) idle(r, r + 1, "R1");

    // R4: load values via matching broadcasts
    cycle(1, 1, 3, 0, 0, 64'd0, 1, 2, "R9");
    idle(1, 2, "R2");
    cycle(0, 0, 1, 1, 3, 64'hAAAA_0000_1111_2222, 1, 2, "R8");
    idle(1, 2, "R4");

    // R5: mismatched broadcast ignored
    cycle(1, 2, 5, 0, 0, 64'd0, 2, 1, "R2");
    cycle(0, 0, 1, 1, 6, 64'hDEAD_BEEF_DEAD_BEEF, 2, 1, "R5");
    idle(2, 1, "R5");

    // R6: later issue supersedes, older result ignored
    cycle(1, 3, 1, 0, 0, 64'd0, 3, 3, "R2");
    cycle(1, 3, 2, 0, 0, 64'd0, 3, 3, "R9");
    cycle(0, 0, 1, 1, 1, 64'h1111_1111_1111_1111, 3, 0, "R6");
    idle(3, 0, "R6");
    cycle(0, 0, 1, 1, 2, 64'h2222_2222_2222_2222, 3, 3, "R8");
    idle(3, 3, "R4");

    // R7: issue and matching broadcast in the same cycle
    cycle(1, 4, 7, 0, 0, 64'd0, 4, 4, "R2");
    cycle(1, 4, 8, 1, 7, 64'h7777_0000_7777_0000, 4, 5, "R7");
    idle(4, 5, "R7");
    cycle(0, 0, 1, 1, 8, 64'h8888_8888_0000_0000, 4, 4, "R4");
    idle(4, 4, "R4");

    // R10: zero-tag and not-valid broadcasts ignored
    cycle(0, 0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 6, "R10");
    idle(1, 6, "R10");
    cycle(1, 6, 9, 0, 0, 64'd0, 6, 6, "R2");
    cycle(0, 0, 1, 0, 9, 64'h9999_9999_9999_9999, 6, 6, "R10");
    idle(6, 6, "R10");

    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      bit w, v;
      int d, t, bt;
      logic [63:0] bd;
      w  = 1'($urandom % 2);
      d  = int'($urandom % NR);
      t  = 1 + int'($urandom % 15);
      v  = 1'($urandom % 2);
      bt = ($urandom % 4 != 0) ? int'(mtag[$urandom % NR]) : int'($urandom % 16);
      bd = {$urandom, $urandom};
      cycle(w, d, t, v, bt, bd, int'($urandom % NR), int'($urandom % NR), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule